// File: doc/BRIEF.md
# FIFO DMA Request Controller

This block drives the DMA request line that links a small data FIFO to a host DMA engine while a disk controller is in the execution phase of a data transfer. It serves both directions. When data moves from the device to the host, it asks the host to drain the FIFO once enough bytes are waiting, or once a whole sector has been captured. When data moves from the host to the device, it asks the host to fill the FIFO, and it uses a threshold on free space so that the request does not toggle on every byte.

The block also tracks the byte position within the current sector and decides how the transfer ends. A terminal count from the host ends the transfer normally. A FIFO overrun, a FIFO underrun or the end of the last sector on the track ends it abnormally. In every case the sector in progress is completed before the result is raised. The FIFO storage, the media serializer and the host bus sit outside the block. They reach it through a registered occupancy count and through one-byte strobes on each side.

Top module: `xfer_dreq_ctrl`

## Requirements
- R1: After reset, and in the cycle after any cycle with `exec_i` low, `dreq_o`, `done_o` and `abnormal_o` are all 0.
- R2: In device-to-host mode (`dir_to_host_i`=1) with `thresh_i` in 1..DEPTH-1, a running transfer whose occupancy `fifo_level_i` is at least DEPTH-`thresh_i` raises `dreq_o` one cycle later. Below that level, with no sector-end flush pending, the request stays low.
- R3: In device-to-host mode, a device strobe that stores the last byte of a sector raises `dreq_o` once the occupancy shows that byte, even when the occupancy is below the threshold level.
- R4: In device-to-host mode, once `dreq_o` is high it stays high while the occupancy is above zero. It drops one cycle after the occupancy reads 0.
- R5: In host-to-device mode (`dir_to_host_i`=0), `dreq_o` rises in the cycle after `exec_i` first goes high. It stays high until the occupancy reads DEPTH and drops one cycle after that.
- R6: In host-to-device mode, after a drop on a full FIFO, `dreq_o` stays low while the free space (DEPTH minus occupancy) is below `thresh_i`. It rises one cycle after the free space reaches `thresh_i`.
- R7: A `tc_i` pulse during a running transfer forces `dreq_o` low from the next cycle, and no request is raised again for that command. Device strobes complete the current sector, and then `done_o` rises with `abnormal_o`=0.
- R8: A device strobe without `dack_i` in the same cycle is an error when the occupancy is DEPTH in device-to-host mode (overrun) or 0 in host-to-device mode (underrun). It stops the request from the next cycle, the sector is still completed, and `done_o` then rises with `abnormal_o`=1.
- R9: When the strobe that completes a sector arrives with `eot_i`=1 and no `tc_i` has been seen, `done_o` rises on the next cycle with `abnormal_o`=1.
- R10: Once `done_o` is high it stays high, `abnormal_o` keeps its value and `dreq_o` stays low, until `exec_i` goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_i | input | 1 | High for the whole execution phase of one command |
| dir_to_host_i | input | 1 | 1: device-to-host transfer, 0: host-to-device transfer |
| thresh_i | input | LVL_W | Programmable threshold in bytes (1..DEPTH-1) |
| fifo_level_i | input | LVL_W | Registered FIFO occupancy in bytes (0..DEPTH) |
| dack_i | input | 1 | Host DMA acknowledge, one byte per strobe |
| tc_i | input | 1 | Host terminal count pulse |
| dev_stb_i | input | 1 | Device side moved one byte (push when to host, pop when from host) |
| eot_i | input | 1 | Current sector is the last one on the track |
| dreq_o | output | 1 | DMA request to the host |
| done_o | output | 1 | Transfer finished, held until `exec_i` falls |
| abnormal_o | output | 1 | Finished transfer ended abnormally (valid with `done_o`) |

## Verification
The assertions assume that `dir_to_host_i` and `thresh_i` stay constant while `exec_i` is high and that `thresh_i` lies in 1..DEPTH-1. They also assume that `fifo_level_i` changes only in step with the byte strobes, so that it never exceeds DEPTH. The stimulus meets these conditions by design. Direction and threshold change only while `exec_i` is low. The occupancy comes from a saturating FIFO model in the bench, which counts host and device strobes by direction. Every strobe is one cycle wide and is driven just after a clock edge.

// File: rtl/xfer_dreq_pkg.sv
// Shared types for the FIFO DMA request controller.
// Assumes nothing beyond being compiled before the modules that import it.
package xfer_dreq_pkg;

    // Command progress seen by the termination logic.
    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,   // outside the execution phase
        XS_RUN  = 2'd1,   // requests allowed
        XS_STOP = 2'd2,   // stop seen, finishing the current sector
        XS_DONE = 2'd3    // result available
    } xfer_st_e;

endpackage

// File: rtl/xfer_sec_cnt.sv
// Byte position counter within the current sector.
// Counts one byte for each enabled device strobe and wraps at SECTOR_BYTES.
// Flags the strobe that completes a sector, and remembers whether any byte
// has moved since the last clear.
// Assumes SECTOR_BYTES >= 2.
module xfer_sec_cnt #(
    parameter int SECTOR_BYTES = 512,
    parameter int SEC_W        = $clog2(SECTOR_BYTES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic stb_i,
    output logic sec_end_o,
    output logic cnt_zero_o,
    output logic moved_o
);

    localparam logic [SEC_W-1:0] LAST_IDX = SEC_W'(SECTOR_BYTES - 1);

    logic [SEC_W-1:0] cnt_q;
    logic             moved_q;

    assign sec_end_o  = stb_i && (cnt_q == LAST_IDX);
    assign cnt_zero_o = (cnt_q == '0);
    assign moved_o    = moved_q;

    // Advance the byte position and wrap at the end of a sector.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q   <= '0;
            moved_q <= 1'b0;
        end else if (stb_i) begin
            cnt_q   <= sec_end_o ? '0 : cnt_q + 1'b1;
            moved_q <= 1'b1;
        end
    end

    // R3: the strobe that completes a sector leaves the counter at zero.
    assert_sector_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_end_o |=> cnt_zero_o);

endmodule

// File: rtl/xfer_term_fsm.sv
// Termination sequencer for one command's execution phase.
// Moves from idle to running on exec_i. Leaves running on a terminal count
// (normal) or on an overrun or underrun (abnormal). Finishes the sector in
// progress and then holds the result until exec_i falls. An end-of-track
// sector ends the command abnormally when no terminal count was seen.
// Assumes fifo_level_i is the registered occupancy (0..DEPTH) and that the
// direction is stable during the phase.
module xfer_term_fsm
    import xfer_dreq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic             dir_i,
    input  logic             tc_i,
    input  logic             dev_stb_i,
    input  logic             dack_i,
    input  logic             eot_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             sec_end_i,
    input  logic             cnt_zero_i,
    input  logic             moved_i,
    output xfer_st_e         state_o,
    output logic             run_nxt_o,
    output logic             start_o,
    output logic             cnt_en_o,
    output logic             cnt_clr_o,
    output logic             done_o,
    output logic             abn_o
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    xfer_st_e st_q, st_n;
    logic     abn_q, abn_n;
    logic     fifo_err;
    logic     stop_fin;

    // The device strobe finds no room (to host) or no data (from host).
    assign fifo_err = dev_stb_i && !dack_i &&
                      (dir_i ? (lvl_i == FULL_LVL) : (lvl_i == '0));

    // After a stop, finish at the sector end. Outside a sector, finish at
    // once, except that host-written bytes still in the FIFO start a sector.
    assign stop_fin = sec_end_i ||
                      (cnt_zero_i && moved_i && (dir_i || (lvl_i == '0)));

    assign state_o   = st_q;
    assign run_nxt_o = (st_n == XS_RUN);
    assign start_o   = (st_q == XS_IDLE) && exec_i;
    assign cnt_en_o  = dev_stb_i && ((st_q == XS_RUN) || (st_q == XS_STOP));
    assign cnt_clr_o = (st_q == XS_IDLE);
    assign done_o    = (st_q == XS_DONE);
    assign abn_o     = (st_q == XS_DONE) && abn_q;

    // Next state and the termination kind.
    always_comb begin
        st_n  = st_q;
        abn_n = abn_q;
        case (st_q)
            XS_IDLE: begin
                abn_n = 1'b0;
                if (exec_i) st_n = XS_RUN;
            end
            XS_RUN: begin
                if (sec_end_i && (tc_i || eot_i || fifo_err)) begin
                    st_n  = XS_DONE;
                    abn_n = !tc_i;
                end else if (tc_i) begin
                    st_n  = XS_STOP;
                    abn_n = 1'b0;
                end else if (fifo_err) begin
                    st_n  = XS_STOP;
                    abn_n = 1'b1;
                end
            end
            XS_STOP: begin
                if (stop_fin) st_n = XS_DONE;
            end
            default: st_n = XS_DONE;
        endcase
        if (!exec_i) begin
            st_n  = XS_IDLE;
            abn_n = 1'b0;
        end
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= XS_IDLE;
            abn_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            abn_q <= abn_n;
        end
    end

    // R7: a terminal count on the sector's last byte ends normally.
    assert_tc_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && st_q == XS_RUN && tc_i && sec_end_i) |=> (done_o && !abn_o));

    // R8: an overrun or underrun leaves the running state and marks abnormal.
    assert_fifo_err_abn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && st_q == XS_RUN && fifo_err && !tc_i) |=> (abn_q && st_q != XS_RUN));

    // R9: an end-of-track sector without terminal count ends abnormally.
    assert_eot_abn_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && st_q == XS_RUN && sec_end_i && eot_i && !tc_i) |=> (done_o && abn_o));

    // R10: the result holds while the phase lasts.
    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exec_i) |=> (done_o && $stable(abn_o)));

endmodule

// File: rtl/xfer_dreq_gen.sv
// Hysteretic DMA request generator.
// Device-to-host: sets on the fill threshold or on a completed sector, and
// clears once the FIFO reads empty. Host-to-device: sets at the phase start
// or when the free space reaches the threshold, and clears once the FIFO
// reads full. The request is registered and is forced low whenever the
// sequencer will not be running in the next cycle.
// Assumes thr_i in 1..DEPTH-1 and lvl_i in 0..DEPTH.
module xfer_dreq_gen #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_i,
    input  logic [LVL_W-1:0] thr_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             start_i,
    input  logic             run_nxt_i,
    input  logic             sec_end_i,
    output logic             dreq_o
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    logic dreq_q, dreq_n;
    logic flush_q;
    logic rd_set, wr_set, lvl_empty, lvl_full;

    assign lvl_empty = (lvl_i == '0);
    assign lvl_full  = (lvl_i == FULL_LVL);
    assign rd_set    = (lvl_i >= (FULL_LVL - thr_i));
    assign wr_set    = ((FULL_LVL - lvl_i) >= thr_i);
    assign dreq_o    = dreq_q;

    // Request for the next cycle, by direction.
    always_comb begin
        if (!run_nxt_i) begin
            dreq_n = 1'b0;
        end else if (dir_i) begin
            dreq_n = rd_set || ((dreq_q || flush_q) && !lvl_empty);
        end else begin
            dreq_n = start_i || wr_set || (dreq_q && !lvl_full);
        end
    end

    // Request register and the flag for a completed sector to be drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            dreq_q <= dreq_n;
            if (run_nxt_i && dir_i && sec_end_i) flush_q <= 1'b1;
            else if (lvl_empty || !run_nxt_i)    flush_q <= 1'b0;
        end
    end

    // R2: filling to the threshold level raises the request.
    assert_rd_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_nxt_i && dir_i && lvl_i >= (FULL_LVL - thr_i)) |=> dreq_o);

    // R4: an empty FIFO drops the request unless a sector just ended.
    assert_rd_empty_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i && lvl_empty && !sec_end_i && thr_i < FULL_LVL) |=> !dreq_o);

    // R5: the phase start raises the request when writing to the device.
    assert_wr_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && run_nxt_i && !dir_i) |=> dreq_o);

    // R5: a full FIFO drops the request when writing to the device.
    assert_wr_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_i && lvl_full && !start_i) |=> !dreq_o);

    // R6: enough free space raises the request again.
    assert_wr_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_nxt_i && !dir_i && (FULL_LVL - lvl_i) >= thr_i) |=> dreq_o);

endmodule

// File: rtl/xfer_dreq_ctrl.sv
// Top of the FIFO DMA request controller.
// Joins the sector counter, the termination sequencer and the request
// generator. All outputs are registered.
// Assumes direction and threshold are stable while exec_i is high, and that
// fifo_level_i is the FIFO's registered occupancy.
module xfer_dreq_ctrl
    import xfer_dreq_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int SECTOR_BYTES = 512,
    parameter int LVL_W        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic             dir_to_host_i,
    input  logic [LVL_W-1:0] thresh_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    input  logic             dack_i,
    input  logic             tc_i,
    input  logic             dev_stb_i,
    input  logic             eot_i,
    output logic             dreq_o,
    output logic             done_o,
    output logic             abnormal_o
);

    localparam int SEC_W = $clog2(SECTOR_BYTES);

    xfer_st_e state;
    logic     run_nxt, start, cnt_en, cnt_clr;
    logic     sec_end, cnt_zero, moved;

    xfer_sec_cnt #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .SEC_W        (SEC_W)
    ) u_sec_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr),
        .stb_i      (cnt_en),
        .sec_end_o  (sec_end),
        .cnt_zero_o (cnt_zero),
        .moved_o    (moved)
    );

    xfer_term_fsm #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_i     (exec_i),
        .dir_i      (dir_to_host_i),
        .tc_i       (tc_i),
        .dev_stb_i  (dev_stb_i),
        .dack_i     (dack_i),
        .eot_i      (eot_i),
        .lvl_i      (fifo_level_i),
        .sec_end_i  (sec_end),
        .cnt_zero_i (cnt_zero),
        .moved_i    (moved),
        .state_o    (state),
        .run_nxt_o  (run_nxt),
        .start_o    (start),
        .cnt_en_o   (cnt_en),
        .cnt_clr_o  (cnt_clr),
        .done_o     (done_o),
        .abn_o      (abnormal_o)
    );

    xfer_dreq_gen #(
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_to_host_i),
        .thr_i     (thresh_i),
        .lvl_i     (fifo_level_i),
        .start_i   (start),
        .run_nxt_i (run_nxt),
        .sec_end_i (sec_end),
        .dreq_o    (dreq_o)
    );

    // R1: outside the execution phase every output returns low.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> (!dreq_o && !done_o && !abnormal_o));

    // R7: a terminal count while running removes the request.
    assert_tc_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i && state == XS_RUN) |=> !dreq_o);

    // R10: no request while a result is shown.
    assert_done_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !dreq_o);

endmodule

// File: tb/xfer_dreq_ctrl_tb_top.sv
// Directed bench for the FIFO DMA request controller.
module xfer_dreq_ctrl_tb_top;

    localparam int DEPTH = 16;
    localparam int SEC   = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             exec_i = 1'b0, dir = 1'b0;
    logic [LVL_W-1:0] thr = LVL_W'(4);
    logic [LVL_W-1:0] lvl;
    logic             dack = 1'b0, tc = 1'b0, dev = 1'b0, eot = 1'b0;
    logic             dreq, done, abn;
    logic             push, pop;
    int               n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    xfer_dreq_ctrl #(.DEPTH(DEPTH), .SECTOR_BYTES(SEC), .LVL_W(LVL_W)) dut_i (
        .clk (clk), .rst_n (rst_n), .exec_i (exec_i), .dir_to_host_i (dir),
        .thresh_i (thr), .fifo_level_i (lvl), .dack_i (dack), .tc_i (tc),
        .dev_stb_i (dev), .eot_i (eot), .dreq_o (dreq), .done_o (done),
        .abnormal_o (abn)
    );

    // Saturating FIFO occupancy model, registered like the real FIFO.
    assign push = dir ? dev : dack;
    assign pop  = dir ? dack : dev;
    always @(posedge clk) begin
        int n;
        n = int'(lvl) + int'(push) - int'(pop);
        if (n < 0) n = 0;
        if (n > DEPTH) n = DEPTH;
        if (!rst_n || !exec_i) lvl <= '0;
        else lvl <= LVL_W'(n);
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic d, input logic a, input logic t, input logic e);
        dev = d; dack = a; tc = t; eot = e;
        @(posedge clk); #1;
        dev = 1'b0; dack = 1'b0; tc = 1'b0; eot = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0);
    endtask

    task automatic dack_n(input int n);
        for (int i = 0; i < n; i++) step(0, 1, 0, 0);
    endtask

    task automatic begin_cmd(input logic to_host, input int th);
        dir = to_host; thr = LVL_W'(th); exec_i = 1'b1;
        idle(1);
    endtask

    task automatic end_cmd();
        exec_i = 1'b0;
        idle(1);
        chk("R1 dreq after phase", dreq, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 dreq reset", dreq, 1'b0);
        chk("R1 done reset", done, 1'b0);
        chk("R1 abnormal reset", abn, 1'b0);
    endtask

    task automatic t_read_main();
        begin_cmd(1'b1, 4);
        push_n(11); idle(1);
        chk("R2 below threshold", dreq, 1'b0);
        push_n(1); idle(1);
        chk("R2 at threshold", dreq, 1'b1);
        dack_n(11); idle(1);
        chk("R4 hold while nonempty", dreq, 1'b1);
        dack_n(1); idle(1);
        chk("R4 drop on empty", dreq, 1'b0);
        push_n(11); dack_n(11); push_n(8); idle(1);
        chk("R3 before sector end", dreq, 1'b0);
        push_n(1); idle(1);
        chk("R3 sector end flush", dreq, 1'b1);
        dack_n(9); idle(1);
        chk("R4 drop after flush", dreq, 1'b0);
        step(0, 0, 1, 0);
        chk("R7 tc drops request", dreq, 1'b0);
        idle(1);
        chk("R7 done at boundary", done, 1'b1);
        chk("R7 normal status", abn, 1'b0);
        idle(3);
        chk("R10 done held", done, 1'b1);
        chk("R10 no request", dreq, 1'b0);
        exec_i = 1'b0; idle(1);
        chk("R10 done cleared", done, 1'b0);
        chk("R1 abnormal cleared", abn, 1'b0);
    endtask

    task automatic t_read_thr8();
        begin_cmd(1'b1, 8);
        push_n(7); idle(1);
        chk("R2 thr8 below", dreq, 1'b0);
        push_n(1); idle(1);
        chk("R2 thr8 at level", dreq, 1'b1);
        end_cmd();
    endtask

    task automatic t_write();
        logic seen;
        begin_cmd(1'b0, 4);
        chk("R5 start request", dreq, 1'b1);
        dack_n(15); idle(1);
        chk("R5 hold until full", dreq, 1'b1);
        dack_n(1); idle(1);
        chk("R5 drop on full", dreq, 1'b0);
        push_n(3); idle(1);
        chk("R6 below free threshold", dreq, 1'b0);
        push_n(1); idle(1);
        chk("R6 reassert", dreq, 1'b1);
        step(0, 1, 1, 0);
        chk("R7 tc drops request", dreq, 1'b0);
        seen = 1'b0;
        for (int i = 0; i < 27; i++) begin
            step(1, 0, 0, 0);
            if (dreq) seen = 1'b1;
        end
        chk("R7 sector not yet done", done, 1'b0);
        push_n(1);
        chk("R7 done at sector end", done, 1'b1);
        chk("R7 normal status", abn, 1'b0);
        chk("R7 no request after tc", seen, 1'b0);
        end_cmd();
    endtask

    task automatic t_overrun();
        begin_cmd(1'b1, 4);
        push_n(16); idle(1);
        chk("R2 full fifo request", dreq, 1'b1);
        push_n(1);
        chk("R8 overrun drops request", dreq, 1'b0);
        push_n(14);
        chk("R8 sector still running", done, 1'b0);
        push_n(1);
        chk("R8 overrun done", done, 1'b1);
        chk("R8 overrun abnormal", abn, 1'b1);
        end_cmd();
    endtask

    task automatic t_underrun();
        begin_cmd(1'b0, 4);
        push_n(1);
        chk("R8 underrun drops request", dreq, 1'b0);
        chk("R8 underrun not done", done, 1'b0);
        push_n(30);
        chk("R8 underrun sector running", done, 1'b0);
        push_n(1);
        chk("R8 underrun done", done, 1'b1);
        chk("R8 underrun abnormal", abn, 1'b1);
        end_cmd();
    endtask

    task automatic t_eot();
        begin_cmd(1'b1, 4);
        for (int i = 0; i < SEC; i++) begin
            step(1, 0, 0, (i == SEC - 1));
            if (i < SEC - 1) step(0, 1, 0, 0);
        end
        chk("R9 eot done", done, 1'b1);
        chk("R9 eot abnormal", abn, 1'b1);
        chk("R9 no request", dreq, 1'b0);
        end_cmd();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        t_reset();
        t_read_main();
        t_read_thr8();
        t_write();
        t_overrun();
        t_underrun();
        t_eot();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule